// File: doc/BRIEF.md
# Interrupt Entry Controller

This block sits beside the fetch/decode stage of a five-stage in-order pipeline. It turns an external interrupt request into a forced control transfer that behaves like a jump. Entry takes a fixed two cycles. In the first cycle the request is accepted. In the second cycle the block redirects fetch to a fixed vector, marks the instruction now in the fetch slot to be replaced by a NOP, and stores that instruction's address as the return address. The replaced instruction is therefore executed again after the handler returns.

A request is never accepted while the decode stage reports a multiply, divide, jump or branch in flight. Because of this, no delay-slot state has to be saved. A request that cannot be taken yet is remembered and taken in the first cycle its blockers are gone. The block has a global enable bit. A one-cycle set pulse turns it on, and the block turns it off on every entry, so the handler cannot be re-entered.

The redirect is a plain one-cycle control pulse with no ready signal. The fetch unit must act on it in the cycle it is high, and the block has no back-pressure path.

Top module: `irq_entry_ctrl`

## Requirements
- R1: During and after synchronous reset (`rst` high), `redir_valid`, `squash_fd`, `epc_we` and `gie` are 0, `epc` is 0, and no earlier request is remembered.
- R2: A request is accepted in a cycle where (`irq_req` is high or a request is remembered) and `gie` is 1 and `inh_flags` is all zero and no entry is in progress. In the following cycle `redir_valid` is 1 for exactly one cycle and `redir_addr` equals parameter `VECTOR`. `redir_addr` is 0 whenever `redir_valid` is 0.
- R3: `squash_fd` is 1 exactly in the cycle where `redir_valid` is 1.
- R4: `epc_we` is 1 in the redirect cycle. In the next cycle `epc` equals the `fd_pc` value present during the redirect cycle.
- R5: Any single set bit of `inh_flags` blocks acceptance. The bits are 0 multiply, 1 divide, 2 jump, 3 branch. A request stays remembered, and `redir_valid` rises in the cycle right after the first cycle in which all flags are clear.
- R6: While `gie` is 0 a request is remembered and not taken. After a `gie_set` pulse, `gie` reads 1 in the next cycle, and the redirect follows one cycle after that.
- R7: `gie` reads 0 from the redirect cycle on. If acceptance and `gie_set` fall in the same cycle, acceptance wins and `gie` becomes 0.
- R8: Each accepted entry consumes the remembered request, so one request pulse produces exactly one entry. A request arriving during an entry is remembered and taken after `gie` is set again.
- R9: `epc` keeps its value in every cycle in which `epc_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 1 | External interrupt request |
| gie_set | input | 1 | One-cycle pulse that sets the global enable |
| inh_flags | input | INH_W | Blockers from decode: bit0 multiply, bit1 divide, bit2 jump, bit3 branch |
| fd_pc | input | AW | Address of the instruction in the fetch/decode slot |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_addr | output | AW | Redirect target (VECTOR while valid, else 0) |
| squash_fd | output | 1 | Replace the fetch-slot instruction with a NOP |
| epc_we | output | 1 | Return-address register is being written this cycle |
| epc | output | AW | Saved return address |
| gie | output | 1 | Global interrupt enable state |

## Verification
The hardest case to reach is a remembered request that waits behind a blocker and must be taken in the exact cycle the blocker clears. Neither the remembered flag nor the acceptance cycle is visible at the ports. The stimulus therefore pulses the request while one inhibit bit is held, keeps that bit for several cycles, and then clears it. The redirect is expected on the very next sampled cycle, and this is repeated for each of the four bits. A second hard case is a request that arrives during an entry, which can only be observed by setting the enable again afterwards. The bench also sets the enable in the same cycle as an acceptance to check that the clear takes priority.

// File: rtl/irqe_pkg.sv
package irqe_pkg;
  localparam int INH_MUL = 0;
  localparam int INH_DIV = 1;
  localparam int INH_JMP = 2;
  localparam int INH_BR  = 3;
  localparam int INH_N   = 4;
endpackage

// File: rtl/irqe_gate.sv
// Remembers requests, holds the global enable, and decides acceptance.
module irqe_gate #(
  parameter int INH_W = irqe_pkg::INH_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_req,
  input  logic             gie_set,
  input  logic [INH_W-1:0] inh,
  input  logic             entry_busy,
  output logic             take,
  output logic             gie
);
  logic pend_q;
  logic gie_q;
  logic want;
  logic blocked;

  assign want    = pend_q | irq_req;
  assign blocked = (|inh) | entry_busy;
  assign take    = want & gie_q & ~blocked;
  assign gie     = gie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      gie_q  <= 1'b0;
    end else begin
      pend_q <= want & ~take;
      if (take)         gie_q <= 1'b0;
      else if (gie_set) gie_q <= 1'b1;
    end
  end

  // R7: after an acceptance the enable is low, so no second acceptance follows
  a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);
  // R6: nothing is accepted without the enable
  a_r6_needs_gie: assert property (@(posedge clk) disable iff (rst)
    !gie_q |-> !take);
endmodule

// File: rtl/irqe_entry.sv
// Second entry slot: redirect, squash and return-address capture.
module irqe_entry #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [AW-1:0] fd_pc,
  output logic          active,
  output logic [AW-1:0] epc
);
  logic          act_q;
  logic [AW-1:0] epc_q;

  assign active = act_q;
  assign epc    = epc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      epc_q <= '0;
    end else begin
      act_q <= take;
      if (act_q) epc_q <= fd_pc;
    end
  end

  // R2: the redirect slot lasts a single cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    act_q |=> !act_q);
  // R4: the return address is the fetch-slot address of the redirect cycle
  a_r4_epc_capture: assert property (@(posedge clk) disable iff (rst)
    act_q |=> (epc_q == $past(fd_pc)));
  // R9: no write, no change
  a_r9_epc_hold: assert property (@(posedge clk) disable iff (rst)
    !act_q |=> $stable(epc_q));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int              AW     = 32,
  parameter int              INH_W  = irqe_pkg::INH_N,
  parameter logic [AW-1:0]   VECTOR = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_req,
  input  logic             gie_set,
  input  logic [INH_W-1:0] inh_flags,
  input  logic [AW-1:0]    fd_pc,
  output logic             redir_valid,
  output logic [AW-1:0]    redir_addr,
  output logic             squash_fd,
  output logic             epc_we,
  output logic [AW-1:0]    epc,
  output logic             gie
);
  logic take;
  logic active;

  irqe_gate #(.INH_W(INH_W)) u_gate (
    .clk(clk), .rst(rst), .irq_req(irq_req), .gie_set(gie_set),
    .inh(inh_flags), .entry_busy(active), .take(take), .gie(gie)
  );

  irqe_entry #(.AW(AW)) u_entry (
    .clk(clk), .rst(rst), .take(take), .fd_pc(fd_pc),
    .active(active), .epc(epc)
  );

  assign redir_valid = active;
  assign redir_addr  = active ? VECTOR : '0;
  assign squash_fd   = active;
  assign epc_we      = active;

  // R5: a redirect only ever follows a cycle with no blocker
  a_r5_no_entry_when_inhibited: assert property (@(posedge clk) disable iff (rst)
    $rose(redir_valid) |-> ($past(inh_flags) == '0));
  // R7: enable is low while the redirect is out
  a_r7_gie_low_in_entry: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> !gie);
endmodule

// File: tb/irq_entry_ctrl_test.sv
module irq_entry_ctrl_test;
  localparam int AW = 32;
  localparam logic [AW-1:0] VEC = 32'h0000_0100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          irq_req = 1'b0;
  logic          gie_set = 1'b0;
  logic [3:0]    inh_flags = 4'b0;
  logic [AW-1:0] fd_pc = 32'h0000_1000;
  logic          redir_valid, squash_fd, epc_we, gie;
  logic [AW-1:0] redir_addr, epc;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  irq_entry_ctrl #(.AW(AW), .VECTOR(VEC)) uut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .gie_set(gie_set),
    .inh_flags(inh_flags), .fd_pc(fd_pc), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .squash_fd(squash_fd), .epc_we(epc_we),
    .epc(epc), .gie(gie)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    #1 fd_pc <= fd_pc + 32'd4;
  end

  // behavioural reference
  bit m_pend = 0, m_gie = 0, m_s2 = 0;
  logic [AW-1:0] m_epc = '0;
  always @(posedge clk) begin
    bit tk;
    if (rst) begin
      m_pend = 0; m_gie = 0; m_s2 = 0; m_epc = '0;
    end else begin
      tk = (m_pend || irq_req) && m_gie && (inh_flags == 0) && !m_s2;
      if (m_s2) m_epc = fd_pc;
      m_pend = (m_pend || irq_req) && !tk;
      if (tk) m_gie = 0; else if (gie_set) m_gie = 1;
      m_s2 = tk;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk(redir_valid == m_s2, "R2 redir_valid", redir_valid, m_s2);
    chk(redir_addr == (m_s2 ? VEC : '0), "R2 redir_addr", redir_addr, m_s2 ? VEC : '0);
    chk(squash_fd == m_s2, "R3 squash_fd", squash_fd, m_s2);
    chk(epc_we == m_s2, "R4 epc_we", epc_we, m_s2);
    chk(epc == m_epc, "R4/R9 epc", epc, m_epc);
    chk(gie == m_gie, "R6/R7 gie", gie, m_gie);
    if (cyc > 20000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_gie();
    gie_set = 1; nclk(1); gie_set = 0;
  endtask

  initial begin
    logic [AW-1:0] pc_seen;
    int seen;
    nclk(3);
    // R1: reset state
    chk(!redir_valid && !squash_fd && !epc_we && !gie && epc == 0, "R1 reset outputs",
        {redir_valid, squash_fd, epc_we, gie}, 0);
    rst = 0;
    nclk(2);
    chk(!redir_valid && !gie, "R1 idle after reset", redir_valid, 0);

    // R6: request while disabled stays remembered
    irq_req = 1; nclk(1); irq_req = 0;
    seen = 0;
    for (int i = 0; i < 5; i++) begin nclk(1); seen += redir_valid; end
    chk(seen == 0, "R6 no entry while disabled", seen, 0);
    gie_set = 1; nclk(1); gie_set = 0;
    chk(gie == 1, "R6 gie set next cycle", gie, 1);
    nclk(1);
    chk(redir_valid && redir_addr == VEC, "R2/R6 redirect after enable", redir_addr, VEC);
    pc_seen = fd_pc;
    chk(squash_fd, "R3 squash in redirect cycle", squash_fd, 1);
    chk(!gie, "R7 gie cleared on entry", gie, 0);
    nclk(1);
    chk(epc == pc_seen, "R4 epc holds replaced address", epc, pc_seen);
    chk(!redir_valid, "R2 single pulse", redir_valid, 0);

    // R5: each blocker holds the request until it clears
    for (int b = 0; b < 4; b++) begin
      pulse_gie();
      inh_flags = 4'b1 << b;
      irq_req = 1; nclk(1); irq_req = 0;
      seen = 0;
      for (int i = 0; i < 4; i++) begin nclk(1); seen += redir_valid; end
      chk(seen == 0, "R5 blocked while inhibit bit set", seen, 0);
      inh_flags = 0;
      nclk(1);
      chk(redir_valid, "R5 entry right after inhibit clears", redir_valid, 1);
      nclk(3);
    end

    // R7: acceptance and gie_set in the same cycle
    pulse_gie();
    irq_req = 1; gie_set = 1; nclk(1); irq_req = 0; gie_set = 0;
    chk(redir_valid, "R7 entry taken", redir_valid, 1);
    nclk(1);
    chk(!gie, "R7 clear beats set", gie, 0);

    // R8: one request gives one entry; request during entry is remembered
    pulse_gie();
    irq_req = 1; nclk(1); irq_req = 0;
    chk(redir_valid, "R8 entry", redir_valid, 1);
    irq_req = 1; nclk(1); irq_req = 0;
    pulse_gie();
    seen = 0;
    for (int i = 0; i < 6; i++) begin nclk(1); seen += redir_valid; end
    chk(seen == 1, "R8 request during entry taken once", seen, 1);
    pulse_gie();
    seen = 0;
    for (int i = 0; i < 6; i++) begin nclk(1); seen += redir_valid; end
    chk(seen == 0, "R8 no spurious entry", seen, 0);
    pc_seen = epc;
    nclk(3);
    chk(epc == pc_seen, "R9 epc stable while idle", epc, pc_seen);

    finish_run();
  end
endmodule